// File: doc/BRIEF.md
# Outstanding Read Tag Tracker with Completion Timeout

This block keeps a table of the outbound read requests that are still waiting for data, indexed by tag. When a request is issued, its slot records the number of bytes still owed and the tick count at the moment of issue. Each returning completion subtracts its byte count from the matching slot, and the slot is released once nothing is owed. A scanner visits one slot per clock. Any live slot whose age in ticks has reached the configured limit is retired and reported on one of two error outputs, fatal or non-fatal, according to a configuration input.

After a timeout the tag is no longer outstanding, so a late completion for it is discarded. In the same way, any completion whose tag is not live is discarded and flagged. A request issued on a tag that is still live is refused, and a sticky error records that it happened. The tick is a free-running prescaled count. With the defaults (prescale 250 at 250 MHz, giving 1 µs ticks, and a 16-bit age), the limit can be set anywhere in the 50 µs to 50 ms range, including the recommended floor of 10 ms.

Top module: `cpl_timeout_tracker`

## Requirements
- R1: After reset all outputs are low, `to_tag_o` is 0, and no tag is outstanding.
- R2: The tick count advances by one every PRESCALE clocks. A request on a free tag makes that tag outstanding and stores `req_bytes_i` (nonzero) and the current tick count.
- R3: A completion on an outstanding tag subtracts `cpl_bytes_i` from the bytes owed. When `cpl_bytes_i` is at least the amount still owed, the tag is freed in that cycle.
- R4: `cpl_last_i` does not free a slot. A tag that still owes bytes after a last completion stays outstanding until it times out.
- R5: The scanner visits tag indices in ascending order, one per clock, and wraps after the highest index; it starts at index 0 after reset. When the visited tag is outstanding and (tick − issue tick) modulo 2^TS_W ≥ `cfg_limit_i`, the tag is freed and a one-cycle error pulse appears in the next cycle, with `to_tag_o` carrying that tag. `to_tag_o` holds its value between pulses.
- R6: The pulse appears on `to_fatal_o` when `cfg_fatal_i` is 1 and on `to_nonfatal_o` when it is 0. The two are never high together.
- R7: A completion on a tag that is not outstanding pulses `cpl_drop_o` in the next cycle and changes no slot. This includes a completion that arrives after its tag has timed out.
- R8: When a completion hits the tag the scanner is visiting in that same cycle, the completion is applied and no timeout is raised for that tag in that cycle.
- R9: A request on an outstanding tag pulses `req_reject_o` in the next cycle and leaves the slot unchanged. It also sets `dup_err_o`, which stays high until reset.
- R10: A tag that was freed, whether by completion or by timeout, can be issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_limit_i | input | TS_W | Timeout limit in ticks |
| cfg_fatal_i | input | 1 | 1: report timeouts as fatal, 0: as non-fatal |
| req_valid_i | input | 1 | Read request issued this cycle |
| req_tag_i | input | TAG_W | Tag of the issued request |
| req_bytes_i | input | BC_W | Bytes requested |
| cpl_valid_i | input | 1 | Completion received this cycle |
| cpl_tag_i | input | TAG_W | Tag of the completion |
| cpl_bytes_i | input | BC_W | Bytes carried by the completion |
| cpl_last_i | input | 1 | Completion marked as last of its request |
| to_fatal_o | output | 1 | Fatal completion-timeout pulse |
| to_nonfatal_o | output | 1 | Non-fatal completion-timeout pulse |
| to_tag_o | output | TAG_W | Tag of the latest timeout |
| cpl_drop_o | output | 1 | Unexpected completion discarded |
| req_reject_o | output | 1 | Request refused because its tag is live |
| dup_err_o | output | 1 | Sticky record of a refused request |

## Verification
The two functions that can coincide are the arrival of a completion and the timeout scan of the same tag. A dedicated phase issues large requests with a short limit, then aims completions at the tag the scanner visits in that cycle. The bench takes the visited index from its own model, so the completion lands exactly on an aged live tag. The cycle-level model applies the completion, expects no timeout pulse from that tag in that cycle, and counts how often the collision actually took place. The run must see it at least once.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  typedef enum logic {
    TO_NONFATAL = 1'b0,
    TO_FATAL    = 1'b1
  } to_class_e;
endpackage

// File: rtl/ctt_tick_gen.sv
module ctt_tick_gen #(
  parameter int PRESCALE = 250,
  parameter int TS_W     = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] now_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PMAX = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      now_o <= '0;
    end else if (cnt_q == PMAX) begin
      cnt_q <= '0;
      now_o <= now_o + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctt_tag_table.sv
module ctt_tag_table #(
  parameter int TAG_W = 5,
  parameter int BC_W  = 12,
  parameter int TS_W  = 16,
  localparam int NUM_TAGS = 1 << TAG_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [TS_W-1:0]                now_i,
  input  logic                           issue_i,
  input  logic [TAG_W-1:0]               issue_tag_i,
  input  logic [BC_W-1:0]                issue_bytes_i,
  input  logic                           hit_i,
  input  logic [TAG_W-1:0]               hit_tag_i,
  input  logic [BC_W-1:0]                hit_bytes_i,
  input  logic                           kill_i,
  input  logic [TAG_W-1:0]               kill_tag_i,
  output logic [NUM_TAGS-1:0]            live_o,
  output logic [NUM_TAGS-1:0][TS_W-1:0]  ts_o
);
  logic [NUM_TAGS-1:0][BC_W-1:0] owed_q;

  for (genvar i = 0; i < NUM_TAGS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_o[i] <= 1'b0;
        owed_q[i] <= '0;
        ts_o[i]   <= '0;
      end else if (issue_i && issue_tag_i == TAG_W'(i)) begin
        live_o[i] <= 1'b1;
        owed_q[i] <= issue_bytes_i;
        ts_o[i]   <= now_i;
      end else if (hit_i && hit_tag_i == TAG_W'(i)) begin
        if (hit_bytes_i >= owed_q[i]) begin
          live_o[i] <= 1'b0;
          owed_q[i] <= '0;
        end else begin
          owed_q[i] <= owed_q[i] - hit_bytes_i;
        end
      end else if (kill_i && kill_tag_i == TAG_W'(i)) begin
        live_o[i] <= 1'b0;
      end
    end
  end

  // an issue only ever lands on a free slot
  AST_ISSUE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !live_o[issue_tag_i]); // R2
  // a hit tag was live and the scan never kills that same tag
  AST_HIT_NOT_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && kill_i) |-> (hit_tag_i != kill_tag_i)); // R8
endmodule

// File: rtl/ctt_scanner.sv
module ctt_scanner #(
  parameter int TAG_W = 5,
  parameter int TS_W  = 16,
  localparam int NUM_TAGS = 1 << TAG_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [TS_W-1:0]                now_i,
  input  logic [TS_W-1:0]                limit_i,
  input  logic [NUM_TAGS-1:0]            live_i,
  input  logic [NUM_TAGS-1:0][TS_W-1:0]  ts_i,
  input  logic                           cpl_valid_i,
  input  logic [TAG_W-1:0]               cpl_tag_i,
  output logic                           kill_o,
  output logic [TAG_W-1:0]               kill_tag_o
);
  logic [TAG_W-1:0] ptr_q;
  logic [TS_W-1:0]  age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_q + 1'b1;
  end

  assign age        = now_i - ts_i[ptr_q];
  assign kill_tag_o = ptr_q;
  // a completion on the scanned tag wins this cycle
  assign kill_o = live_i[ptr_q] && (age >= limit_i) &&
                  !(cpl_valid_i && cpl_tag_i == ptr_q);
endmodule

// File: rtl/cpl_timeout_tracker.sv
module cpl_timeout_tracker #(
  parameter int TAG_W    = 5,
  parameter int BC_W     = 12,
  parameter int TS_W     = 16,
  parameter int PRESCALE = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TS_W-1:0]  cfg_limit_i,
  input  logic             cfg_fatal_i,
  input  logic             req_valid_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic [BC_W-1:0]  req_bytes_i,
  input  logic             cpl_valid_i,
  input  logic [TAG_W-1:0] cpl_tag_i,
  input  logic [BC_W-1:0]  cpl_bytes_i,
  input  logic             cpl_last_i,
  output logic             to_fatal_o,
  output logic             to_nonfatal_o,
  output logic [TAG_W-1:0] to_tag_o,
  output logic             cpl_drop_o,
  output logic             req_reject_o,
  output logic             dup_err_o
);
  import ctt_pkg::*;
  localparam int NUM_TAGS = 1 << TAG_W;

  logic [TS_W-1:0]                now;
  logic [NUM_TAGS-1:0]            live;
  logic [NUM_TAGS-1:0][TS_W-1:0]  ts;
  logic                           kill;
  logic [TAG_W-1:0]               kill_tag;
  logic                           issue, clash, hit, stray;
  to_class_e                      cls;

  // last flag carries no meaning for slot release: only the byte count does
  logic unused_last;
  assign unused_last = cpl_last_i;

  assign issue = req_valid_i && !live[req_tag_i];
  assign clash = req_valid_i &&  live[req_tag_i];
  assign hit   = cpl_valid_i &&  live[cpl_tag_i];
  assign stray = cpl_valid_i && !live[cpl_tag_i];
  assign cls   = cfg_fatal_i ? TO_FATAL : TO_NONFATAL;

  ctt_tick_gen #(.PRESCALE(PRESCALE), .TS_W(TS_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .now_o (now)
  );

  ctt_tag_table #(.TAG_W(TAG_W), .BC_W(BC_W), .TS_W(TS_W)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .now_i        (now),
    .issue_i      (issue),
    .issue_tag_i  (req_tag_i),
    .issue_bytes_i(req_bytes_i),
    .hit_i        (hit),
    .hit_tag_i    (cpl_tag_i),
    .hit_bytes_i  (cpl_bytes_i),
    .kill_i       (kill),
    .kill_tag_i   (kill_tag),
    .live_o       (live),
    .ts_o         (ts)
  );

  ctt_scanner #(.TAG_W(TAG_W), .TS_W(TS_W)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .now_i      (now),
    .limit_i    (cfg_limit_i),
    .live_i     (live),
    .ts_i       (ts),
    .cpl_valid_i(cpl_valid_i),
    .cpl_tag_i  (cpl_tag_i),
    .kill_o     (kill),
    .kill_tag_o (kill_tag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_fatal_o    <= 1'b0;
      to_nonfatal_o <= 1'b0;
      to_tag_o      <= '0;
      cpl_drop_o    <= 1'b0;
      req_reject_o  <= 1'b0;
      dup_err_o     <= 1'b0;
    end else begin
      to_fatal_o    <= kill && (cls == TO_FATAL);
      to_nonfatal_o <= kill && (cls == TO_NONFATAL);
      if (kill) to_tag_o <= kill_tag;
      cpl_drop_o    <= stray;
      req_reject_o  <= clash;
      if (clash) dup_err_o <= 1'b1;
    end
  end

  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(to_fatal_o && to_nonfatal_o)); // R6
  AST_DUP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_err_o |=> dup_err_o); // R9
  AST_REJ_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_reject_o |-> dup_err_o); // R9
  AST_CPL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_fatal_o || to_nonfatal_o) |->
      !($past(cpl_valid_i) && $past(cpl_tag_i) == to_tag_o)); // R8
  AST_DROP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_drop_o |-> $past(cpl_valid_i)); // R7
endmodule

// File: tb/tb_cpl_timeout_tracker.sv
`timescale 1ns/1ps
module tb_cpl_timeout_tracker;
  localparam int TAG_W = 5;
  localparam int BC_W  = 10;
  localparam int TS_W  = 12;
  localparam int PRE   = 2;
  localparam int NT    = 1 << TAG_W;

  logic clk = 0, rst_n = 0;
  logic [TS_W-1:0] lim = 12'd40;
  logic fatal = 1'b1;
  logic rv = 0, cv = 0, cl = 0;
  logic [TAG_W-1:0] rt = '0, ct = '0;
  logic [BC_W-1:0] rb = '0, cb = '0;
  logic o_f, o_n, o_d, o_r, o_dup;
  logic [TAG_W-1:0] o_t;

  always #2 clk = ~clk;

  cpl_timeout_tracker #(.TAG_W(TAG_W), .BC_W(BC_W), .TS_W(TS_W), .PRESCALE(PRE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_limit_i(lim), .cfg_fatal_i(fatal),
    .req_valid_i(rv), .req_tag_i(rt), .req_bytes_i(rb),
    .cpl_valid_i(cv), .cpl_tag_i(ct), .cpl_bytes_i(cb), .cpl_last_i(cl),
    .to_fatal_o(o_f), .to_nonfatal_o(o_n), .to_tag_o(o_t),
    .cpl_drop_o(o_d), .req_reject_o(o_r), .dup_err_o(o_dup));

  // reference model state
  bit m_live[NT];
  int m_owed[NT];
  int m_ts[NT];
  int m_now, m_pre, m_ptr;
  bit e_f, e_n, e_d, e_r, e_dup;
  int e_t;
  int n_cmp = 0, n_bad = 0;
  int c_fat = 0, c_nf = 0, c_drop = 0, c_rej = 0, c_clash = 0, c_free = 0, c_late = 0, c_reuse = 0;
  bit was_to[NT];
  bit done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_live[i]) begin m_live[i] = 0; m_owed[i] = 0; m_ts[i] = 0; was_to[i] = 0; end
      m_now = 0; m_pre = 0; m_ptr = 0;
      e_f = 0; e_n = 0; e_d = 0; e_r = 0; e_dup = 0; e_t = 0;
    end else begin
      bit aged, kill, hit, acc, stray;
      aged  = m_live[m_ptr] && (((m_now - m_ts[m_ptr]) & ((1 << TS_W) - 1)) >= int'(lim));
      kill  = aged && !(cv && int'(ct) == m_ptr);
      if (aged && cv && int'(ct) == m_ptr) c_clash++;
      hit   = cv && m_live[ct];
      stray = cv && !m_live[ct];
      acc   = rv && !m_live[rt];
      if (stray && was_to[ct]) c_late++;
      e_f = kill && fatal;
      e_n = kill && !fatal;
      if (kill) e_t = m_ptr;
      e_d = stray;
      e_r = rv && m_live[rt];
      if (e_r) e_dup = 1;
      if (hit) begin
        if (int'(cb) >= m_owed[ct]) begin m_live[ct] = 0; m_owed[ct] = 0; c_free++; end
        else m_owed[ct] -= int'(cb);
      end
      if (kill) begin m_live[m_ptr] = 0; was_to[m_ptr] = 1; end
      if (acc) begin
        if (was_to[rt]) c_reuse++;
        m_live[rt] = 1; m_owed[rt] = int'(rb); m_ts[rt] = m_now; was_to[rt] = 0;
      end
      m_ptr = (m_ptr + 1) % NT;
      if (m_pre == PRE - 1) begin m_pre = 0; m_now = (m_now + 1) % (1 << TS_W); end
      else m_pre++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 to_fatal_o (R5)", int'(o_f), int'(e_f));
    chk("R6 to_nonfatal_o (R5)", int'(o_n), int'(e_n));
    chk("R5 to_tag_o", int'(o_t), e_t);
    chk("R7 cpl_drop_o (R3,R4)", int'(o_d), int'(e_d));
    chk("R9 req_reject_o (R2)", int'(o_r), int'(e_r));
    chk("R9 dup_err_o", int'(o_dup), int'(e_dup));
    if (o_f) c_fat++;
    if (o_n) c_nf++;
    if (o_d) c_drop++;
    if (o_r) c_rej++;
  end

  task automatic idle();
    rv = 0; cv = 0; cl = 0;
  endtask

  task automatic traffic(input int cycles, input bit chase, input int maxreq);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      rv = ($urandom_range(3) == 0);
      rt = TAG_W'($urandom_range(NT - 1));
      rb = BC_W'($urandom_range(maxreq, 1));
      cv = ($urandom_range(2) == 0);
      ct = TAG_W'($urandom_range(NT - 1));
      cb = BC_W'($urandom_range(32, 1));
      cl = $urandom_range(1);
      if (chase && $urandom_range(1) == 0) begin
        cv = 1; ct = TAG_W'(m_ptr); cb = 1;
      end
    end
    @(negedge clk); idle();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs at reset
    chk("R1 to_fatal_o", int'(o_f), 0);
    chk("R1 to_nonfatal_o", int'(o_n), 0);
    chk("R1 cpl_drop_o", int'(o_d), 0);
    chk("R1 dup_err_o", int'(o_dup), 0);
    rst_n = 1;
    // R1: nothing outstanding -> completion dropped
    @(negedge clk); cv = 1; ct = 5; cb = 4;
    @(negedge clk); idle();
    // R2,R3: issue then full completion frees; R10 reuse
    @(negedge clk); rv = 1; rt = 3; rb = 8;
    @(negedge clk); rv = 0; cv = 1; ct = 3; cb = 3; cl = 1;   // R4 last, partial
    @(negedge clk); cb = 5; cl = 0;                            // R3 frees
    @(negedge clk); cb = 1;                                    // R7 drop
    @(negedge clk); cv = 0; rv = 1; rt = 3; rb = 2;            // R10 reuse
    @(negedge clk); rt = 3;                                    // R9 reject
    @(negedge clk); idle();
    repeat (200) @(negedge clk);                               // R5 tag 3 times out
    traffic(3000, 0, 64);
    fatal = 0;
    traffic(3000, 0, 64);
    lim = 12'd10;
    traffic(3000, 1, 600);
    repeat (300) @(negedge clk);
    chk("R6 fatal timeouts seen", int'(c_fat > 0), 1);
    chk("R6 nonfatal timeouts seen", int'(c_nf > 0), 1);
    chk("R7 drops seen", int'(c_drop > 0), 1);
    chk("R7 late completion after timeout dropped", int'(c_late > 0), 1);
    chk("R9 rejects seen", int'(c_rej > 0), 1);
    chk("R8 completion/scan collisions seen", int'(c_clash > 0), 1);
    chk("R3 frees seen", int'(c_free > 0), 1);
    chk("R10 reuse after timeout seen", int'(c_reuse > 0), 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule